// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block estimates the frequency of an on-chip clock by counting its edges during a window of known length. The window is timed by the reference clock, which is also the clock of the register interface. One of up to 32 primary clocks or up to 7 alternate clocks is routed to a counter. The counter can count every edge or every fourth edge, and the count is returned to software when the window has closed and the count has stopped changing.

Software prepares a measurement through two 32-bit words. It sets the window length, pulses the soft reset, sets the enable bit, and then sets the start bit. It then polls start, which reads back as a busy flag, until hardware clears it, and reads the count. The frequency is computed in software as count × f_ref / (window cycles) × prescale. The window gate goes to the measured-clock domain through a two-stage synchroniser, and the gate is echoed back the same way. The count is taken only after the echo has dropped. A source that never toggles gives a count of zero after a bounded drain timeout.

Top module: `refwin_fmeter`

## Requirements
- R1: After rst_n low, the control word (wr_addr/rd_addr 0) reads 0x0000_8000 (soft-reset bit 15 high, all else 0) and the count word (address 1) reads 0.
- R2: A control write with bit 4 (start) and bit 12 (enable) both set, while idle and while bit 15 is already 1, begins a measurement. Bit 4 reads 1 from the cycle after the write until the measurement ends, then reads 0 within (window + 1 + DRAIN_LIMIT + 3) cycles.
- R3: The window length field is count-word bits [25:16] (W) and reads back as written. The gate stays open for exactly W+1 reference cycles.
- R4: Control bits [25:24] = 3 count one per four edges of the measured clock. Any other value counts every edge. The result, in count-word bits [15:0], is within ±3 of floor(edges/prescale), where edges are those in the W+1 cycle window.
- R5: When control bits [2:0] are 0, control bits [20:16] pick the primary source src_clk[index].
- R6: When control bits [2:0] hold n ≠ 0, alternate source alt_clk[n-1] is measured.
- R7: The result saturates at 0xFFFF and does not wrap.
- R8: A start write while busy is ignored. The measurement is not restarted or extended.
- R9: Writing control bit 15 as 0 aborts a measurement. Within two cycles busy reads 0 and the result reads 0. A start written while bit 15 is 0 is ignored.
- R10: A selected source with no edges still ends the measurement within the R2 bound, with result 0.
- R11: A start write with bit 12 clear is ignored, and bit 4 stays 0.
- R12: While idle, the result holds its value, including across writes to the window field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control word, 1 count word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 control word, 1 count word |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| src_clk | input | NUM_SRC | Primary clocks to be measured |
| alt_clk | input | NUM_ALT | Alternate clocks to be measured |

## Verification
Busy is set on the edge that captures the start write, so it is due one cycle after the write. An abort is registered on one edge and acted on at the next, so busy and result are due two cycles after the abort write. The count is due only when busy reads 0, so the bench polls busy every cycle and checks that the poll ends within W+1 plus the drain limit plus a small margin. The count itself passes through two synchronisers in each direction, so it is compared against the edges expected in W+1 cycles with a tolerance of ±3.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
// Shared widths, field positions and types for the reference-window meter.
package fm_pkg;
    localparam int CNT_W  = 16;   // result counter width
    localparam int WIN_W  = 10;   // window length field width
    localparam int PSEL_W = 5;    // primary source select width
    localparam int ASEL_W = 3;    // alternate source select width
    localparam int PRE_W  = 2;    // prescaler mode width

    // Control word bit positions
    localparam int C_ASEL  = 0;
    localparam int C_START = 4;
    localparam int C_EN    = 12;
    localparam int C_SRST  = 15;
    localparam int C_PSEL  = 16;
    localparam int C_PRE   = 24;
    // Count word bit positions
    localparam int K_WIN   = 16;

    localparam logic [PRE_W-1:0] PRE_QUARTER = 2'd3;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_OPEN,
        WS_DRAIN
    } win_state_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [PSEL_W-1:0] psel;
        logic              srst_n;
        logic              en;
        logic [ASEL_W-1:0] asel;
    } ctl_t;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchroniser.
// Assumes: d changes slowly relative to clk; STAGES >= 2.
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the input through the chain of flops
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
`timescale 1ns/1ps
// Register file for the meter: control word and count word.
// Assumes: bus shares the reference clock. While busy only the soft-reset
// bit is writable, so source, prescaler and window are frozen during a run.
module fm_regs
    import fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_addr,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic [CNT_W-1:0]  result,
    output ctl_t              ctl,
    output logic [WIN_W-1:0]  win_len,
    output logic              start_pulse
);
    logic [31:0] ctl_word;
    logic [31:0] cnt_word;
    logic        unused_wr_bits;

    // Capture register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '{pre: '0, psel: '0, srst_n: 1'b1, en: 1'b0, asel: '0};
            win_len <= '0;
        end else if (wr_en) begin
            if (!wr_addr) begin
                ctl.srst_n <= wr_data[C_SRST];
                if (!busy) begin
                    ctl.pre  <= wr_data[C_PRE +: PRE_W];
                    ctl.psel <= wr_data[C_PSEL +: PSEL_W];
                    ctl.en   <= wr_data[C_EN];
                    ctl.asel <= wr_data[C_ASEL +: ASEL_W];
                end
            end else if (!busy) begin
                win_len <= wr_data[K_WIN +: WIN_W];
            end
        end
    end

    // Qualify a start request: enabled, out of soft reset, idle
    always_comb begin
        start_pulse = wr_en && !wr_addr && wr_data[C_START] && wr_data[C_EN]
                      && ctl.srst_n && !busy;
    end

    // Assemble read words
    always_comb begin
        ctl_word                     = '0;
        ctl_word[C_ASEL +: ASEL_W]   = ctl.asel;
        ctl_word[C_START]            = busy;
        ctl_word[C_EN]               = ctl.en;
        ctl_word[C_SRST]             = ctl.srst_n;
        ctl_word[C_PSEL +: PSEL_W]   = ctl.psel;
        ctl_word[C_PRE +: PRE_W]     = ctl.pre;
        cnt_word                     = '0;
        cnt_word[0 +: CNT_W]         = result;
        cnt_word[K_WIN +: WIN_W]     = win_len;
        rd_data = rd_addr ? cnt_word : ctl_word;
    end

    assign unused_wr_bits = ^{wr_data[31:26], wr_data[23:21], wr_data[14:13],
                              wr_data[11:5], wr_data[3]};
endmodule

// File: rtl/fm_window.sv
`timescale 1ns/1ps
// Reference-domain sequencer: opens the gate for win_len+1 cycles, then
// drains until the measured domain's echo of the gate has dropped, and only
// then copies the frozen count. If the echo is never seen, the drain times
// out after DRAIN_LIMIT cycles and the result is 0.
// Assumes: meas_count is stable whenever ack has been low after being high.
module fm_window
    import fm_pkg::*;
#(
    parameter int DRAIN_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic              start_pulse,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              ack,
    input  logic [CNT_W-1:0]  meas_count,
    output logic              busy,
    output logic              gate,
    output logic [CNT_W-1:0]  result
);
    localparam int TMR_W = $clog2(DRAIN_LIMIT + 1);

    win_state_e        state;
    logic [WIN_W-1:0]  win_cnt;
    logic [TMR_W-1:0]  timer;
    logic              seen;

    // Window, drain and capture sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !srst_n) begin
            state   <= WS_IDLE;
            busy    <= 1'b0;
            gate    <= 1'b0;
            result  <= '0;
            win_cnt <= '0;
            timer   <= '0;
            seen    <= 1'b0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (start_pulse) begin
                        busy    <= 1'b1;
                        gate    <= 1'b1;
                        win_cnt <= win_len;
                        seen    <= 1'b0;
                        timer   <= '0;
                        state   <= WS_OPEN;
                    end
                end
                WS_OPEN: begin
                    if (ack) seen <= 1'b1;
                    if (win_cnt == '0) begin
                        gate  <= 1'b0;
                        state <= WS_DRAIN;
                    end else begin
                        win_cnt <= win_cnt - 1'b1;
                    end
                end
                WS_DRAIN: begin
                    if (ack) seen <= 1'b1;
                    timer <= timer + 1'b1;
                    if (seen && !ack) begin
                        result <= meas_count;
                        busy   <= 1'b0;
                        state  <= WS_IDLE;
                    end else if (timer == TMR_W'(DRAIN_LIMIT - 1)) begin
                        result <= '0;
                        busy   <= 1'b0;
                        state  <= WS_IDLE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fm_meas_counter.sv
`timescale 1ns/1ps
// Measured-clock domain: selects the source clock, synchronises the gate,
// and counts every edge or every fourth edge while the gate is open.
// The counter saturates at all-ones and is cleared when the gate opens.
// Assumes: selects and mode are static while a window is open.
module fm_meas_counter
    import fm_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int NUM_ALT     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [NUM_ALT-1:0] alt_clk,
    input  logic [PSEL_W-1:0]  psel,
    input  logic [ASEL_W-1:0]  asel,
    input  logic [PRE_W-1:0]   pre_mode,
    input  logic               gate_ref,
    output logic               gate_echo,
    output logic [CNT_W-1:0]   count
);
    localparam int PRIM_N = 2 ** PSEL_W;
    localparam int ALT_N  = 2 ** ASEL_W;

    logic [PRIM_N-1:0] prim_pad;
    logic [ALT_N-1:0]  alt_pad;
    logic              mclk;
    logic              gate_m;
    logic              gate_d;
    logic [1:0]        pre_cnt;
    logic              tick;

    // Pad the source lists so every select code maps to a clock (0 if absent)
    for (genvar i = 0; i < PRIM_N; i++) begin : g_prim
        if (i < NUM_SRC) begin : g_on
            assign prim_pad[i] = src_clk[i];
        end else begin : g_off
            assign prim_pad[i] = 1'b0;
        end
    end
    assign alt_pad[0] = 1'b0;
    for (genvar j = 1; j < ALT_N; j++) begin : g_alt
        if (j - 1 < NUM_ALT) begin : g_on
            assign alt_pad[j] = alt_clk[j-1];
        end else begin : g_off
            assign alt_pad[j] = 1'b0;
        end
    end

    // Route the chosen clock: alternate group wins when its select is nonzero
    always_comb begin
        mclk = (asel != '0) ? alt_pad[asel] : prim_pad[psel];
    end

    fm_sync #(.STAGES(SYNC_STAGES)) u_gsync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     (gate_ref),
        .q     (gate_m)
    );

    // Count-enable: every edge, or every fourth edge in quarter mode
    always_comb begin
        tick = (pre_mode != PRE_QUARTER) || (pre_cnt == 2'd3);
    end

    // Edge counter with clear on gate opening and saturation
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            gate_d  <= 1'b0;
            pre_cnt <= '0;
            count   <= '0;
        end else begin
            gate_d <= gate_m;
            if (gate_m && !gate_d) begin
                pre_cnt <= '0;
                count   <= '0;
            end else if (gate_m) begin
                pre_cnt <= pre_cnt + 1'b1;
                if (tick && (count != '1)) count <= count + 1'b1;
            end
        end
    end

    assign gate_echo = gate_m;
endmodule

// File: rtl/refwin_fmeter.sv
`timescale 1ns/1ps
// Reference-window clock frequency meter, top level.
// Registers and window timing run on clk (the reference). The chosen source
// is counted in its own domain; the gate crosses there and is echoed back.
// Assumes: NUM_SRC <= 32, NUM_ALT <= 7, DRAIN_LIMIT larger than the
// round-trip synchroniser latency for the slowest source in use.
module refwin_fmeter
    import fm_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int NUM_ALT     = 7,
    parameter int SYNC_STAGES = 2,
    parameter int DRAIN_LIMIT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [NUM_ALT-1:0] alt_clk
);
    ctl_t             ctl;
    logic [WIN_W-1:0] win_len;
    logic             start_pulse;
    logic             busy;
    logic             gate_ref;
    logic             gate_echo;
    logic             ack_ref;
    logic [CNT_W-1:0] meas_count;
    logic [CNT_W-1:0] result;
    logic             srst_n;

    assign srst_n = ctl.srst_n;

    fm_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .result      (result),
        .ctl         (ctl),
        .win_len     (win_len),
        .start_pulse (start_pulse)
    );

    fm_window #(.DRAIN_LIMIT(DRAIN_LIMIT)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_n      (srst_n),
        .start_pulse (start_pulse),
        .win_len     (win_len),
        .ack         (ack_ref),
        .meas_count  (meas_count),
        .busy        (busy),
        .gate        (gate_ref),
        .result      (result)
    );

    fm_meas_counter #(
        .NUM_SRC     (NUM_SRC),
        .NUM_ALT     (NUM_ALT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cnt (
        .rst_n     (rst_n),
        .src_clk   (src_clk),
        .alt_clk   (alt_clk),
        .psel      (ctl.psel),
        .asel      (ctl.asel),
        .pre_mode  (ctl.pre),
        .gate_ref  (gate_ref),
        .gate_echo (gate_echo),
        .count     (meas_count)
    );

    fm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_echo),
        .q     (ack_ref)
    );
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
// Property checker for refwin_fmeter, attached by bind.
module fm_checker
    import fm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             srst_n,
    input logic             busy,
    input logic             gate_ref,
    input logic [CNT_W-1:0] result,
    input logic [WIN_W-1:0] win_len
);
    logic [WIN_W:0] open_cycles;

    // Count consecutive cycles the gate has been open
    always_ff @(posedge clk) begin
        if (!rst_n)        open_cycles <= '0;
        else if (gate_ref) open_cycles <= open_cycles + 1'b1;
        else               open_cycles <= '0;
    end

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n |=> (!busy && result == '0));

    p_gate_inside_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ref |-> busy);

    p_gate_opens_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ref) |-> $rose(busy));

    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && srst_n && $past(srst_n)) |-> $stable(result));

    p_busy_after_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(srst_n)) |-> (!gate_ref && !$past(gate_ref)));

    p_gate_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_ref) && $past(srst_n)) |->
            (open_cycles == ({1'b0, $past(win_len)} + 1'b1)));
endmodule

bind refwin_fmeter fm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n   (srst_n),
    .busy     (busy),
    .gate_ref (gate_ref),
    .result   (result),
    .win_len  (win_len)
);

// File: tb/sim_refwin_fmeter.sv
`timescale 1ns/1ps
module sim_refwin_fmeter;
    localparam int DRAIN = 32;
    localparam real TREF = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] src_clk;
    logic [6:0]  alt_clk;

    logic c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, c6 = 0, c7 = 0;
    logic a0 = 0, a1 = 0;
    logic fast_on = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    real per [8] = '{10.0, 7.0, 13.0, 31.0, 0.2, 0.0, 23.0, 4.4};

    always #10   clk = ~clk;
    always #5.0  c0 = ~c0;
    always #3.5  c1 = ~c1;
    always #6.5  c2 = ~c2;
    always #15.5 c3 = ~c3;
    always #11.5 c6 = ~c6;
    always #2.2  c7 = ~c7;
    always #5.5  a0 = ~a0;
    always #4.5  a1 = ~a1;
    always begin
        wait (fast_on);
        while (fast_on) #0.1 c4 = ~c4;
    end

    assign src_clk = {24'b0, c7, c6, 1'b0, c4, c3, c2, c1, c0};
    assign alt_clk = {5'b0, a1, a0};

    refwin_fmeter #(.DRAIN_LIMIT(DRAIN)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .src_clk (src_clk),
        .alt_clk (alt_clk)
    );

    task automatic wr(input bit a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        int diff;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        n_checks++;
        if (diff > 3) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d(+-3)", req, act, exp);
        end
    endtask

    task automatic check_le(input string req, input int act, input int lim);
        n_checks++;
        if (act > lim) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    function automatic logic [31:0] fld(input int psel, input int asel, input int pre);
        return (32'(pre) << 24) | (32'(psel) << 16) | 32'(asel);
    endfunction

    function automatic int exp_cnt(input real p, input int win, input bit quarter);
        int edges;
        if (p == 0.0) return 0;
        edges = int'($floor((win + 1) * TREF / p));
        if (quarter) edges = edges / 4;
        if (edges > 65535) edges = 65535;
        return edges;
    endfunction

    function automatic int bound(input int win);
        return win + 1 + DRAIN + 3;
    endfunction

    // Full software sequence; optional second start at cycle restart_at
    task automatic measure(input logic [31:0] f, input int win, input int restart_at,
                           output int res, output int cyc);
        logic [31:0] d;
        wr(1, 32'(win) << 16);
        wr(0, f | 32'h8000);
        wr(0, f);
        wr(0, f | 32'h8000);
        wr(0, f | 32'h9000);
        wr(0, f | 32'h9010);
        cyc = 0;
        while (cyc < 5000) begin
            if (cyc == restart_at) begin
                wr(0, f | 32'h9010);
                cyc++;
                rd(0, d);
                check_eq("R8 busy stays set after repeated start", int'(d[4]), 1);
            end
            rd(0, d);
            if (!d[4]) break;
            @(negedge clk);
            cyc++;
        end
        rd(1, d);
        res = int'(d[15:0]);
    endtask

    initial begin
        logic [31:0] d;
        int res, cyc, held;
        void'($urandom(32'h0F1E2D3C));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, d); check_eq("R1 control word after reset", int'(d), 32'h8000);
        rd(1, d); check_eq("R1 count word after reset", int'(d), 0);

        // R11 start without enable
        wr(0, 32'h0000_8010);
        rd(0, d); check_eq("R11 start without enable ignored", int'(d[4]), 0);

        // R3 window field readback
        wr(1, 32'h03FF_0000);
        rd(1, d); check_eq("R3 window field readback", int'(d[25:16]), 32'h3FF);

        // R2 busy set the cycle after start
        wr(1, 32'h0010_0000);
        wr(0, fld(0, 0, 0) | 32'h9000);
        wr(0, fld(0, 0, 0) | 32'h9010);
        rd(0, d); check_eq("R2 busy one cycle after start", int'(d[4]), 1);
        repeat (60) @(negedge clk);
        rd(0, d); check_eq("R2 busy cleared by hardware", int'(d[4]), 0);

        // R5 primary select, every edge
        measure(fld(1, 0, 0), 63, -1, res, cyc);
        check_near("R5 primary source 1 count", res, exp_cnt(per[1], 63, 0));
        check_le("R2 completion time", cyc, bound(63));

        // R4 quarter mode on same source
        measure(fld(1, 0, 3), 63, -1, res, cyc);
        check_near("R4 quarter prescale count", res, exp_cnt(per[1], 63, 1));

        // R4 mode value 2 counts every edge
        measure(fld(3, 0, 2), 99, -1, res, cyc);
        check_near("R4 mode 2 counts every edge", res, exp_cnt(per[3], 99, 0));

        // R6 alternate select n=2 -> alt_clk[1]
        measure(fld(1, 2, 0), 99, -1, res, cyc);
        check_near("R6 alternate source count", res, exp_cnt(9.0, 99, 0));

        // R7 saturation with a very fast source
        fast_on = 1'b1;
        measure(fld(4, 0, 0), 1023, -1, res, cyc);
        check_eq("R7 count saturates", res, 65535);
        measure(fld(4, 0, 3), 1023, -1, res, cyc);
        check_near("R4 quarter mode on fast source", res, exp_cnt(per[4], 1023, 1));
        fast_on = 1'b0;

        // R10 dead source
        measure(fld(5, 0, 0), 40, -1, res, cyc);
        check_eq("R10 dead source result", res, 0);
        check_le("R10 dead source completion", cyc, bound(40));

        // R8 repeated start while busy
        measure(fld(0, 0, 0), 200, 20, res, cyc);
        check_near("R8 result after ignored restart", res, exp_cnt(per[0], 200, 0));
        check_le("R8 no extension of window", cyc, bound(200));

        // R12 result held while idle and across window writes
        held = res;
        repeat (30) @(negedge clk);
        wr(1, 32'h0005_0000);
        rd(1, d);
        check_eq("R12 result held while idle", int'(d[15:0]), held);
        check_eq("R3 window field written while idle", int'(d[25:16]), 5);

        // R9 abort mid-measurement
        wr(1, 32'h03FF_0000);
        wr(0, fld(2, 0, 0) | 32'h9000);
        wr(0, fld(2, 0, 0) | 32'h9010);
        repeat (50) @(negedge clk);
        wr(0, fld(2, 0, 0));
        @(negedge clk);
        rd(0, d); check_eq("R9 abort clears busy", int'(d[4]), 0);
        rd(1, d); check_eq("R9 abort zeroes result", int'(d[15:0]), 0);
        wr(0, fld(2, 0, 0) | 32'h1010);
        rd(0, d); check_eq("R9 start ignored in soft reset", int'(d[4]), 0);
        wr(0, fld(2, 0, 0) | 32'h8000);
        repeat (20) @(negedge clk);

        // Constrained random measurements (R5, R4)
        for (int it = 0; it < 8; it++) begin
            int idx, win, pre;
            int pick [6] = '{0, 1, 2, 3, 6, 7};
            bit q;
            idx = pick[$urandom % 6];
            win = 16 + int'($urandom % 240);
            pre = int'($urandom % 4);
            q   = (pre == 3);
            measure(fld(idx, 0, pre), win, -1, res, cyc);
            check_near("R5 random source count", res, exp_cnt(per[idx], win, q));
            check_le("R2 random completion", cyc, bound(win));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule